// File: doc/BRIEF.md
# Two-Way Level-One Data Cache with Posted Write Buffer

This block is a 4 KB level-one data cache for the load/store port of a signal processor core. Reads that find their line present return the word on the next cycle. A read that misses fetches the whole 32-byte line from the next memory level as eight 32-bit beats. The requested word goes back to the core once the line is complete.

Every store is write-through. A store is posted into a four-entry buffer that retires one word at a time to the next level. A store that finds its line present also updates the cached copy. A store that misses leaves the cache untouched, so the cache never holds dirty data. The buffer must be empty before a line fill is requested, which keeps a fill from returning stale data.

A single invalidate input clears every line by walking through the sets, one set per cycle. The core is held off until the walk is done.

Top module: `dcache2w`

## Requirements
- R1: The address splits into a word index in bits [4:2], a set index in bits [10:5] (64 sets) and a tag in bits [31:11]. Each set holds two ways of eight 32-bit words. A word of a line that has been filled hits no matter which word caused the fill, and an address with the same set but a different tag does not hit.
- R2: A read accepted on a hit raises cpu_rvalid in the following cycle with the stored word, and issues no request on the fill port.
- R3: A read miss issues one single-cycle nl_rd_req with a line-aligned nl_rd_addr. The cache takes eight beats on nl_rd_valid as words 0 to 7 of the line, in order. It then returns the requested word on cpu_rvalid, and the line hits from then on.
- R4: nl_rd_req is raised only when the write buffer is empty, after every store accepted earlier has been written out. A read miss waits for as long as the next level withholds nl_wr_ready.
- R5: Each accepted store appears exactly once on the write port, in the order the stores were accepted, with its address and data.
- R6: A store that hits updates the cached word, so a later read of that address hits and returns the new data without a fill.
- R7: A store that misses does not allocate a line. A later read of that line misses, fills, and returns the stored data.
- R8: The write buffer holds four stores. While it is full, cpu_ready is low for a store request until an entry retires.
- R9: A fill goes to way 0 if it is invalid, else to way 1 if that is invalid, else to the least recently used way of the set. Read hits, store hits and fills all mark their way as most recently used.
- R10: A pulse on inval_all holds cpu_ready low for 65 cycles when the cache is idle: one cycle, then one cycle per set. Afterwards every line is invalid.
- R11: After reset cpu_ready is high, and cpu_rvalid, nl_rd_req and nl_wr_valid are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Core request valid |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Word-aligned byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Request accepted on this edge when high |
| cpu_rvalid | output | 1 | Load data valid |
| cpu_rdata | output | 32 | Load data |
| nl_rd_req | output | 1 | Line fill request pulse |
| nl_rd_addr | output | 32 | Line-aligned fill address |
| nl_rd_valid | input | 1 | Fill beat valid |
| nl_rd_data | input | 32 | Fill beat data |
| nl_wr_valid | output | 1 | Buffered store presented |
| nl_wr_ready | input | 1 | Next level takes the store |
| nl_wr_addr | output | 32 | Store address |
| nl_wr_data | output | 32 | Store data |
| inval_all | input | 1 | Invalidate every line |

## Verification
A hit is due exactly one cycle after the accepting edge. The bench therefore samples cpu_rvalid and cpu_rdata at the first falling edge after acceptance and compares them with a hit/miss prediction from its own tag and recency model. A miss has no fixed latency, because it depends on how long draining and the fill take. For a miss the bench polls falling edges until cpu_rvalid and also checks that exactly one fill request went out. The invalidate stall is counted cycle by cycle against 65, and the buffer stall is read at cpu_ready one instant after the store request is driven.

// File: rtl/dcache2w.sv
module dcache2w #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int SETS       = 64,
  parameter int LINE_WORDS = 8,
  parameter int WB_DEPTH   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic          cpu_rvalid,
  output logic [DW-1:0] cpu_rdata,
  output logic          nl_rd_req,
  output logic [AW-1:0] nl_rd_addr,
  input  logic          nl_rd_valid,
  input  logic [DW-1:0] nl_rd_data,
  output logic          nl_wr_valid,
  input  logic          nl_wr_ready,
  output logic [AW-1:0] nl_wr_addr,
  output logic [DW-1:0] nl_wr_data,
  input  logic          inval_all
);
  localparam int OFF_W = $clog2(LINE_WORDS * DW / 8);
  localparam int WRD_W = $clog2(LINE_WORDS);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = AW - SET_W - OFF_W;
  localparam int WBP_W = $clog2(WB_DEPTH);
  localparam int IDX_W = SET_W + WRD_W;

  typedef enum logic [2:0] {S_IDLE, S_DRAIN, S_FREQ, S_FILL, S_RESP, S_INV} st_t;
  st_t state;

  logic [DW-1:0]    dmem [2][SETS*LINE_WORDS];
  logic [TAG_W-1:0] tags [2][SETS];
  logic [SETS-1:0]  vld  [2];
  logic [SETS-1:0]  lru;

  logic [AW-1:0]    wb_a [WB_DEPTH];
  logic [DW-1:0]    wb_d [WB_DEPTH];
  logic [WBP_W-1:0] wb_h, wb_t;
  logic [WBP_W:0]   wb_cnt;

  logic [AW-1:0]    m_addr;
  logic             vic, inv_pend, rvalid_q;
  logic [DW-1:0]    rdata_q;
  logic [WRD_W-1:0] beat;
  logic [SET_W-1:0] scan;

  wire [WRD_W-1:0] a_wrd = cpu_addr[OFF_W-1:2];
  wire [SET_W-1:0] a_set = cpu_addr[OFF_W+SET_W-1:OFF_W];
  wire [TAG_W-1:0] a_tag = cpu_addr[AW-1:OFF_W+SET_W];
  wire [WRD_W-1:0] m_wrd = m_addr[OFF_W-1:2];
  wire [SET_W-1:0] m_set = m_addr[OFF_W+SET_W-1:OFF_W];
  wire [TAG_W-1:0] m_tag = m_addr[AW-1:OFF_W+SET_W];

  wire hit0 = vld[0][a_set] && (tags[0][a_set] == a_tag);
  wire hit1 = vld[1][a_set] && (tags[1][a_set] == a_tag);
  wire hit  = hit0 | hit1;
  wire hway = hit1;
  wire vic_c = !vld[0][a_set] ? 1'b0 : (!vld[1][a_set] ? 1'b1 : lru[a_set]);

  wire wb_full = (wb_cnt == (WBP_W+1)'(WB_DEPTH));
  assign cpu_ready = (state == S_IDLE) && !inv_pend && !(cpu_we && wb_full);
  wire acc    = cpu_req && cpu_ready;
  wire st_acc = acc && cpu_we;
  wire rd_acc = acc && !cpu_we;

  assign nl_wr_valid = (wb_cnt != '0);
  assign nl_wr_addr  = wb_a[wb_h];
  assign nl_wr_data  = wb_d[wb_h];
  wire wb_pop = nl_wr_valid && nl_wr_ready;

  assign nl_rd_req  = (state == S_FREQ);
  assign nl_rd_addr = {m_addr[AW-1:OFF_W], {OFF_W{1'b0}}};
  assign cpu_rvalid = rvalid_q;
  assign cpu_rdata  = rdata_q;

  always_ff @(posedge clk) begin
    if (st_acc && hit) dmem[hway][IDX_W'({a_set, a_wrd})] <= cpu_wdata;
    if (state == S_FILL && nl_rd_valid) dmem[vic][IDX_W'({m_set, beat})] <= nl_rd_data;
    if (state == S_FILL && nl_rd_valid && beat == WRD_W'(LINE_WORDS-1)) tags[vic][m_set] <= m_tag;
    if (st_acc) begin
      wb_a[wb_t] <= cpu_addr;
      wb_d[wb_t] <= cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      vld[0]   <= '0;
      vld[1]   <= '0;
      lru      <= '0;
      wb_h     <= '0;
      wb_t     <= '0;
      wb_cnt   <= '0;
      m_addr   <= '0;
      vic      <= 1'b0;
      inv_pend <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      beat     <= '0;
      scan     <= '0;
    end else begin
      rvalid_q <= 1'b0;
      if (inval_all) inv_pend <= 1'b1;
      if (st_acc) wb_t <= wb_t + 1'b1;
      if (wb_pop) wb_h <= wb_h + 1'b1;
      wb_cnt <= wb_cnt + (WBP_W+1)'(st_acc) - (WBP_W+1)'(wb_pop);
      case (state)
        S_IDLE: begin
          if (inv_pend) begin
            state    <= S_INV;
            scan     <= '0;
            inv_pend <= inval_all;
          end else if (rd_acc && hit) begin
            rvalid_q   <= 1'b1;
            rdata_q    <= dmem[hway][IDX_W'({a_set, a_wrd})];
            lru[a_set] <= !hway;
          end else if (rd_acc) begin
            m_addr <= cpu_addr;
            vic    <= vic_c;
            state  <= S_DRAIN;
          end else if (st_acc && hit) begin
            lru[a_set] <= !hway;
          end
        end
        S_DRAIN: if (wb_cnt == '0) state <= S_FREQ;
        S_FREQ: begin
          vld[vic][m_set] <= 1'b0;
          beat  <= '0;
          state <= S_FILL;
        end
        S_FILL: if (nl_rd_valid) begin
          beat <= beat + 1'b1;
          if (beat == WRD_W'(LINE_WORDS-1)) begin
            vld[vic][m_set] <= 1'b1;
            lru[m_set]      <= !vic;
            state           <= S_RESP;
          end
        end
        S_RESP: begin
          rvalid_q <= 1'b1;
          rdata_q  <= dmem[vic][IDX_W'({m_set, m_wrd})];
          state    <= S_IDLE;
        end
        S_INV: begin
          vld[0][scan] <= 1'b0;
          vld[1][scan] <= 1'b0;
          scan <= scan + 1'b1;
          if (scan == SET_W'(SETS-1)) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_fill_after_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nl_rd_req |-> (wb_cnt == '0));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cnt <= (WBP_W+1)'(WB_DEPTH));

  assert_hit_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && hit) |=> cpu_rvalid);

  assert_store_miss_no_alloc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_acc && !hit) |=> (vld[0] == $past(vld[0]) && vld[1] == $past(vld[1])));

  assert_scan_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_INV) |=> (!vld[0][$past(scan)] && !vld[1][$past(scan)]));
endmodule

// File: tb/dcache2w_bench.sv
module dcache2w_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cpu_req = 0, cpu_we = 0, inval_all = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic        cpu_ready, cpu_rvalid, nl_rd_req, nl_wr_valid;
  logic [31:0] cpu_rdata, nl_rd_addr, nl_wr_addr, nl_wr_data;
  logic        nl_rd_valid = 0, nl_wr_ready = 0;
  logic [31:0] nl_rd_data = 0;

  dcache2w u_dcache2w (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .nl_rd_req(nl_rd_req),
    .nl_rd_addr(nl_rd_addr), .nl_rd_valid(nl_rd_valid), .nl_rd_data(nl_rd_data),
    .nl_wr_valid(nl_wr_valid), .nl_wr_ready(nl_wr_ready), .nl_wr_addr(nl_wr_addr),
    .nl_wr_data(nl_wr_data), .inval_all(inval_all)
  );

  int total = 0, bad = 0, fills = 0;
  logic [31:0] nl_mem [4096];
  logic [31:0] shadow [4096];
  logic [31:0] pq_a [1024];
  logic [31:0] pq_d [1024];
  int pq_h = 0, pq_t = 0;
  bit rv [2][64];
  logic [20:0] rt [2][64];
  bit rl [64];
  bit wr_hold = 0, rnd_mode = 0;
  int f_wait = 0, f_left = 0;
  logic [31:0] f_base = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_way(logic [31:0] a);
    for (int w = 0; w < 2; w++)
      if (rv[w][a[10:5]] && rt[w][a[10:5]] == a[31:11]) return w;
    return -1;
  endfunction

  function automatic void ref_fill(logic [31:0] a);
    int v;
    v = !rv[0][a[10:5]] ? 0 : (!rv[1][a[10:5]] ? 1 : int'(rl[a[10:5]]));
    rv[v][a[10:5]] = 1;
    rt[v][a[10:5]] = a[31:11];
    rl[a[10:5]] = (v == 0);
  endfunction

  function automatic logic [31:0] init_word(int i);
    return (i * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  always @(posedge clk) begin
    nl_wr_ready <= !wr_hold && (!rnd_mode || ($urandom % 4 != 0));
    if (nl_wr_valid && nl_wr_ready) begin
      nl_mem[nl_wr_addr[13:2]] <= nl_wr_data;
      chk(pq_h != pq_t && nl_wr_addr == pq_a[pq_h % 1024] && nl_wr_data == pq_d[pq_h % 1024],
          "R5", nl_wr_data, pq_d[pq_h % 1024]);
      pq_h++;
    end
    nl_rd_valid <= 1'b0;
    if (nl_rd_req) begin
      fills++;
      chk(pq_h == pq_t, "R4", pq_t - pq_h, 0);
      chk(nl_rd_addr[4:0] == 0, "R3", nl_rd_addr, {nl_rd_addr[31:5], 5'd0});
      f_base <= nl_rd_addr;
      f_left <= 8;
      f_wait <= 2;
    end else if (f_wait > 0) begin
      f_wait <= f_wait - 1;
    end else if (f_left > 0 && (!rnd_mode || $urandom % 3 != 0)) begin
      nl_rd_valid <= 1'b1;
      nl_rd_data  <= nl_mem[f_base[13:2] + 12'(8 - f_left)];
      f_left <= f_left - 1;
    end
  end

  task automatic do_read(logic [31:0] a, string req);
    int w, n, f0;
    logic [31:0] exp;
    w = ref_way(a);
    exp = shadow[a[13:2]];
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = a;
    #1;
    while (!cpu_ready) begin @(negedge clk); #1; end
    f0 = fills;
    @(posedge clk);
    @(negedge clk);
    cpu_req = 0;
    if (w >= 0) begin
      chk(cpu_rvalid == 1, req, cpu_rvalid, 1);
      chk(cpu_rdata == exp, req, cpu_rdata, exp);
      chk(fills == f0, req, fills, f0);
      rl[a[10:5]] = (w == 0);
    end else begin
      n = 0;
      while (!cpu_rvalid && n < 200) begin @(negedge clk); n++; end
      chk(cpu_rvalid == 1, req, cpu_rvalid, 1);
      chk(cpu_rdata == exp, req, cpu_rdata, exp);
      chk(fills == f0 + 1, req, fills, f0 + 1);
      ref_fill(a);
    end
  endtask

  task automatic do_write(logic [31:0] a, logic [31:0] d);
    int w;
    w = ref_way(a);
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    #1;
    while (!cpu_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
    shadow[a[13:2]] = d;
    pq_a[pq_t % 1024] = a;
    pq_d[pq_t % 1024] = d;
    pq_t++;
    if (w >= 0) rl[a[10:5]] = (w == 0);
  endtask

  function automatic logic [31:0] mk(int tg, int st, int wd);
    return (32'(tg) << 11) | (32'(st) << 5) | (32'(wd) << 2);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, f0;
    for (int i = 0; i < 4096; i++) begin nl_mem[i] = init_word(i); shadow[i] = init_word(i); end
    for (int s = 0; s < 64; s++) begin rv[0][s] = 0; rv[1][s] = 0; rl[s] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    chk(cpu_ready == 1, "R11", cpu_ready, 1);
    chk(cpu_rvalid == 0, "R11", cpu_rvalid, 0);
    chk(nl_rd_req == 0, "R11", nl_rd_req, 0);
    chk(nl_wr_valid == 0, "R11", nl_wr_valid, 0);

    do_read(mk(0, 5, 3), "R3");
    do_read(mk(0, 5, 7), "R1");
    do_read(mk(1, 5, 0), "R1");
    do_read(mk(0, 5, 3), "R2");
    do_read(mk(2, 5, 1), "R9");
    do_read(mk(0, 5, 2), "R9");
    do_read(mk(1, 5, 4), "R9");

    do_write(mk(0, 5, 2), 32'hCAFE0001);
    do_read(mk(0, 5, 2), "R6");

    do_write(mk(0, 9, 6), 32'hBEEF0002);
    do_read(mk(0, 9, 6), "R7");

    n = 0;
    while (nl_wr_valid && n < 100) begin @(negedge clk); n++; end
    wr_hold = 1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) do_write(mk(3, i, i), 32'h1000 + i);
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = mk(3, 7, 0); cpu_wdata = 32'h2000;
    #1;
    chk(cpu_ready == 0, "R8", cpu_ready, 0);
    repeat (3) @(negedge clk);
    #1;
    chk(cpu_ready == 0, "R8", cpu_ready, 0);
    wr_hold = 0;
    n = 0;
    while (!cpu_ready && n < 100) begin @(negedge clk); #1; n++; end
    chk(cpu_ready == 1, "R8", cpu_ready, 1);
    @(posedge clk);
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
    shadow[mk(3, 7, 0) >> 2] = 32'h2000;
    pq_a[pq_t % 1024] = mk(3, 7, 0);
    pq_d[pq_t % 1024] = 32'h2000;
    pq_t++;

    n = 0;
    while (nl_wr_valid && n < 100) begin @(negedge clk); n++; end
    wr_hold = 1;
    do_write(mk(4, 12, 1), 32'h3333);
    f0 = fills;
    fork
      do_read(mk(5, 13, 0), "R4");
      begin
        repeat (20) @(negedge clk);
        chk(fills == f0, "R4", fills, f0);
        wr_hold = 0;
      end
    join

    do_read(mk(0, 20, 0), "R10");
    @(negedge clk) inval_all = 1;
    @(posedge clk);
    @(negedge clk) inval_all = 0;
    n = 0;
    #1;
    while (!cpu_ready && n < 500) begin n++; @(negedge clk); #1; end
    chk(n == 65, "R10", n, 65);
    for (int s = 0; s < 64; s++) begin rv[0][s] = 0; rv[1][s] = 0; end
    do_read(mk(0, 20, 0), "R10");

    rnd_mode = 1;
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a;
      a = mk($urandom % 3, $urandom % 8, $urandom % 8);
      if ($urandom % 2 == 0) do_write(a, $urandom);
      else do_read(a, "R2");
    end
    rnd_mode = 0;
    n = 0;
    while (nl_wr_valid && n < 200) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
    chk(pq_h == pq_t, "R5", pq_h, pq_t);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule